// File: doc/BRIEF.md
# 8-bit ALU with binary and packed-decimal arithmetic

This block is the arithmetic and logic unit of a small 8-bit accumulator processor. Each cycle in which `in_valid` is high, it takes an operation code, the register operand (accumulator, or the index register for a compare), the memory operand, and the current carry and decimal-mode flags. One clock later it presents the 8-bit result together with new values for the negative (N), overflow (V), zero (Z) and carry (C) flags. A separate write-enable bit for each flag tells the surrounding core which flags the operation updates.

Add-with-carry and subtract-with-borrow work in plain binary or, when the decimal flag is set, on two packed BCD digits. The decimal flag derivations follow the classic 8-bit behaviour. Z comes from the unadjusted binary sum. N and V come from the sum before the upper-digit correction. On subtraction, carry acts as an inverted borrow. The remaining operations are compare, the three bitwise logic operations, operand load, shifts, rotates through carry, increment, decrement and bit test. Register storage, sequencing and memory access belong to the surrounding core.

Top module: `acc_alu8`

## Requirements
- R1: Operation codes on `op_i` are 0 add, 1 subtract, 2 compare, 3 AND, 4 OR, 5 XOR, 6 shift left, 7 logical shift right, 8 rotate left, 9 rotate right, 10 increment, 11 decrement, 12 bit test, 13 load. Each accepted operation produces its result and flags with `out_valid` high exactly one cycle later. `out_valid` is low in the cycle after an idle one. Reset clears `out_valid`, the result and every write enable.
- R2: Binary add (decimal flag low) gives A+M+C. C is bit 8 of that sum. N and Z follow the low byte. V is set when A and M have the same sign and the result's sign differs from A's. All four flags are written.
- R3: Binary subtract gives A-M-(1-C). C is set when no borrow occurs. V is set when A and M differ in sign and the result's sign differs from A's. N and Z follow the result. All four flags are written.
- R4: Decimal add first sums the low digits plus carry. A digit sum of 10 or more becomes (sum+6) mod 16 plus a carry of 0x10 into the upper sum. If the full sum reaches 0xA0, 0x60 is added, and C is set when that adjusted value exceeds 0xFF. Z comes from the plain binary A+M+C. N is bit 7 of the sum before the 0x60 correction. V is set when that sum, taken with signed upper digits, falls outside -128..127.
- R5: Decimal subtract takes 6 from the low digit when it borrows, and takes 0x60 from the result when the whole subtraction borrows out of bit 8. C, Z and V are taken from the plain binary A-M-(1-C). N is bit 7 of the corrected result.
- R6: Compare returns the register operand unchanged as the result. It sets C when register ≥ operand, Z on equality and N from bit 7 of the difference. It writes N, Z and C but not V.
- R7: AND, OR, XOR and load (which returns M) write only N and Z, from the result. The C and V write enables stay low.
- R8: Shift left moves A's bit 7 into C and fills bit 0 with zero. Logical shift right moves bit 0 into C and fills bit 7 with zero. Both write N, Z and C.
- R9: Rotate left places the incoming carry in bit 0 and bit 7 in C. Rotate right places the incoming carry in bit 7 and bit 0 in C. Both write N, Z and C.
- R10: Increment and decrement of A wrap modulo 256 and write only N and Z.
- R11: Bit test returns A unchanged. It copies M bit 7 to N and M bit 6 to V, and sets Z when A AND M is zero. It writes N, V and Z but not C.
- R12: The decimal flag affects only add and subtract. Codes 14 and 15 return A with every flag write enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code (see R1) |
| acc_i | input | 8 | Register operand A |
| opd_i | input | 8 | Memory operand M |
| carry_i | input | 1 | Incoming carry flag |
| dec_i | input | 1 | Decimal-mode flag |
| out_valid | output | 1 | Result and flags valid |
| result_o | output | 8 | Operation result |
| flag_n_o | output | 1 | New negative flag |
| flag_v_o | output | 1 | New overflow flag |
| flag_z_o | output | 1 | New zero flag |
| flag_c_o | output | 1 | New carry flag |
| wr_n_o | output | 1 | Write enable for N |
| wr_v_o | output | 1 | Write enable for V |
| wr_z_o | output | 1 | Write enable for Z |
| wr_c_o | output | 1 | Write enable for C |

## Verification
The properties assume that `in_valid` stays low from reset assertion until the internal reset synchronizer has released. They also assume that operand, flag and code inputs are known whenever `in_valid` is high. The stimulus holds `in_valid` low through reset and several cycles after it, and always drives every input at once. Decimal-mode results are specified for any byte, not only for valid BCD digits. The random sweep therefore feeds unconstrained bytes with the decimal flag toggled, alongside directed cases built on valid digits.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned DW  = 8;
  localparam int unsigned OPW = 4;
  localparam int unsigned NIB = DW / 2;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_SHL = 4'd6,
    OP_SHR = 4'd7,
    OP_ROL = 4'd8,
    OP_ROR = 4'd9,
    OP_INC = 4'd10,
    OP_DEC = 4'd11,
    OP_BIT = 4'd12,
    OP_LD  = 4'd13
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/acc_alu_rst_sync.sv
module acc_alu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/acc_alu_bin_addsub.sv
// Binary add / subtract; subtract is A + ~M + C so carry means "no borrow".
module acc_alu_bin_addsub
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          c_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output alu_flags_t    flg_o
);
  logic [DW-1:0] opnd;
  logic [DW:0]   wide;

  always_comb begin
    opnd    = sub_i ? ~m_i : m_i;
    wide    = {1'b0, a_i} + {1'b0, opnd} + {{DW{1'b0}}, c_i};
    res_o   = wide[DW-1:0];
    flg_o.c = wide[DW];
    flg_o.n = wide[DW-1];
    flg_o.z = ~|wide[DW-1:0];
    // same-sign operands (after inversion for subtract) with a sign flip
    flg_o.v = ~(a_i[DW-1] ^ opnd[DW-1]) & (a_i[DW-1] ^ wide[DW-1]);
  end
endmodule

// File: rtl/acc_alu_bcd_addsub.sv
// Two-digit packed decimal add / subtract with the classic flag derivations.
module acc_alu_bcd_addsub
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          c_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output alu_flags_t    flg_o
);
  localparam logic [NIB:0]  DIGIT_LIM = (NIB+1)'(10);
  localparam logic [DW:0]   HI_LIM    = (DW+1)'(8'hA0);
  localparam logic [DW+1:0] HI_FIX    = (DW+2)'(8'h60);

  // add path
  logic [NIB:0]      lo_sum, lo_adj;
  logic [DW:0]       hi_sum;
  logic [DW+1:0]     add_fix;
  logic signed [DW+1:0] add_sgn;
  logic [DW-1:0]     add_plain;
  // subtract path
  logic              bw;
  logic [NIB:0]      lo_dif;
  logic              lo_bw;
  logic [NIB-1:0]    lo_cor;
  logic [NIB:0]      hi_dif;
  logic [DW:0]       pre_cor;
  logic [DW:0]       sub_plain;
  logic [DW-1:0]     sub_res;

  always_comb begin
    // ---- add ----
    lo_sum    = {1'b0, a_i[NIB-1:0]} + {1'b0, m_i[NIB-1:0]} + {{NIB{1'b0}}, c_i};
    lo_adj    = (lo_sum >= DIGIT_LIM) ? {1'b1, lo_sum[NIB-1:0] + NIB'(6)} : lo_sum;
    hi_sum    = {1'b0, a_i[DW-1:NIB], {NIB{1'b0}}}
              + {1'b0, m_i[DW-1:NIB], {NIB{1'b0}}}
              + {{(DW-NIB){1'b0}}, lo_adj};
    add_fix   = {1'b0, hi_sum} + ((hi_sum >= HI_LIM) ? HI_FIX : '0);
    add_sgn   = $signed({{2{a_i[DW-1]}}, a_i[DW-1:NIB], {NIB{1'b0}}})
              + $signed({{2{m_i[DW-1]}}, m_i[DW-1:NIB], {NIB{1'b0}}})
              + $signed({{(DW-NIB+1){1'b0}}, lo_adj});
    add_plain = a_i + m_i + {{(DW-1){1'b0}}, c_i};

    // ---- subtract ----
    bw        = ~c_i;
    lo_dif    = {1'b0, a_i[NIB-1:0]} - {1'b0, m_i[NIB-1:0]} - {{NIB{1'b0}}, bw};
    lo_bw     = lo_dif[NIB];
    lo_cor    = lo_bw ? (lo_dif[NIB-1:0] - NIB'(6)) : lo_dif[NIB-1:0];
    hi_dif    = {1'b0, a_i[DW-1:NIB]} - {1'b0, m_i[DW-1:NIB]} - {{NIB{1'b0}}, lo_bw};
    pre_cor   = {hi_dif, lo_cor};
    sub_res   = pre_cor[DW] ? (pre_cor[DW-1:0] - 8'h60) : pre_cor[DW-1:0];
    sub_plain = {1'b0, a_i} - {1'b0, m_i} - {{DW{1'b0}}, bw};

    if (sub_i) begin
      res_o   = sub_res;
      flg_o.n = sub_res[DW-1];
      flg_o.c = ~sub_plain[DW];
      flg_o.z = ~|sub_plain[DW-1:0];
      flg_o.v = (a_i[DW-1] ^ sub_plain[DW-1]) & (a_i[DW-1] ^ m_i[DW-1]);
    end else begin
      res_o   = add_fix[DW-1:0];
      flg_o.n = hi_sum[DW-1];
      flg_o.c = |add_fix[DW+1:DW];
      flg_o.z = ~|add_plain;
      flg_o.v = (add_sgn > $signed((DW+2)'(127))) || (add_sgn < -$signed((DW+2)'(128)));
    end
  end
endmodule

// File: rtl/acc_alu_bitops.sv
// Logic, load, shifts, rotates, increment/decrement and bit test.
module acc_alu_bitops
  import acc_alu_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          c_i,
  output logic [DW-1:0] res_o,
  output alu_flags_t    flg_o
);
  always_comb begin
    res_o = a_i;
    flg_o = '0;
    flg_o.c = c_i;
    case (op_i)
      OP_AND: res_o = a_i & m_i;
      OP_OR:  res_o = a_i | m_i;
      OP_XOR: res_o = a_i ^ m_i;
      OP_LD:  res_o = m_i;
      OP_INC: res_o = a_i + {{(DW-1){1'b0}}, 1'b1};
      OP_DEC: res_o = a_i - {{(DW-1){1'b0}}, 1'b1};
      OP_SHL: begin res_o = {a_i[DW-2:0], 1'b0}; flg_o.c = a_i[DW-1]; end
      OP_SHR: begin res_o = {1'b0, a_i[DW-1:1]}; flg_o.c = a_i[0];    end
      OP_ROL: begin res_o = {a_i[DW-2:0], c_i};  flg_o.c = a_i[DW-1]; end
      OP_ROR: begin res_o = {c_i, a_i[DW-1:1]};  flg_o.c = a_i[0];    end
      default: res_o = a_i;
    endcase
    flg_o.n = res_o[DW-1];
    flg_o.z = ~|res_o;
    if (op_i == OP_BIT) begin
      flg_o.n = m_i[DW-1];
      flg_o.v = m_i[DW-2];
      flg_o.z = ~|(a_i & m_i);
    end
  end
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
  import acc_alu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  opd_i,
  input  logic           carry_i,
  input  logic           dec_i,
  output logic           out_valid,
  output logic [DW-1:0]  result_o,
  output logic           flag_n_o,
  output logic           flag_v_o,
  output logic           flag_z_o,
  output logic           flag_c_o,
  output logic           wr_n_o,
  output logic           wr_v_o,
  output logic           wr_z_o,
  output logic           wr_c_o
);
  localparam int unsigned RST_STAGES = 2;

  logic       rst_q_n;
  alu_op_e    op_e;
  logic       bin_sub, bin_cin, bcd_sub;
  logic [DW-1:0] bin_res, bcd_res, bit_res;
  alu_flags_t    bin_flg, bcd_flg, bit_flg;

  logic [DW-1:0] res_d, res_q;
  alu_flags_t    flg_d, flg_q, wen_d, wen_q;
  logic          vld_q;

  acc_alu_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  assign op_e    = alu_op_e'(op_i);
  assign bin_sub = (op_e != OP_ADD);
  assign bin_cin = (op_e == OP_CMP) ? 1'b1 : carry_i;
  assign bcd_sub = (op_e == OP_SUB);

  acc_alu_bin_addsub u_bin (
    .a_i   (acc_i),
    .m_i   (opd_i),
    .c_i   (bin_cin),
    .sub_i (bin_sub),
    .res_o (bin_res),
    .flg_o (bin_flg)
  );

  acc_alu_bcd_addsub u_bcd (
    .a_i   (acc_i),
    .m_i   (opd_i),
    .c_i   (carry_i),
    .sub_i (bcd_sub),
    .res_o (bcd_res),
    .flg_o (bcd_flg)
  );

  acc_alu_bitops u_bits (
    .op_i  (op_e),
    .a_i   (acc_i),
    .m_i   (opd_i),
    .c_i   (carry_i),
    .res_o (bit_res),
    .flg_o (bit_flg)
  );

  // next-state selection and flag write enables
  always_comb begin
    res_d = acc_i;
    flg_d = '0;
    wen_d = '0;
    case (op_e)
      OP_ADD, OP_SUB: begin
        res_d = dec_i ? bcd_res : bin_res;
        flg_d = dec_i ? bcd_flg : bin_flg;
        wen_d = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
      end
      OP_CMP: begin
        res_d   = acc_i;
        flg_d   = bin_flg;
        flg_d.v = 1'b0;
        wen_d   = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
      end
      OP_AND, OP_OR, OP_XOR, OP_LD, OP_INC, OP_DEC: begin
        res_d = bit_res;
        flg_d = '{n: bit_flg.n, v: 1'b0, z: bit_flg.z, c: 1'b0};
        wen_d = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        res_d = bit_res;
        flg_d = '{n: bit_flg.n, v: 1'b0, z: bit_flg.z, c: bit_flg.c};
        wen_d = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
      end
      OP_BIT: begin
        res_d = acc_i;
        flg_d = '{n: bit_flg.n, v: bit_flg.v, z: bit_flg.z, c: 1'b0};
        wen_d = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b0};
      end
      default: begin
        res_d = acc_i;
        flg_d = '0;
        wen_d = '0;
      end
    endcase
  end

  // output registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      flg_q <= '0;
      wen_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        flg_q <= flg_d;
        wen_q <= wen_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign result_o  = res_q;
  assign flag_n_o  = flg_q.n;
  assign flag_v_o  = flg_q.v;
  assign flag_z_o  = flg_q.z;
  assign flag_c_o  = flg_q.c;
  assign wr_n_o    = wen_q.n;
  assign wr_v_o    = wen_q.v;
  assign wr_z_o    = wen_q.z;
  assign wr_c_o    = wen_q.c;
endmodule

// File: rtl/acc_alu8_chk.sv
module acc_alu8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [3:0] op_i,
  input logic [7:0] acc_i,
  input logic [7:0] opd_i,
  input logic       carry_i,
  input logic       dec_i,
  input logic       out_valid,
  input logic [7:0] result_o,
  input logic       flag_z_o,
  input logic       flag_c_o,
  input logic       wr_n_o,
  input logic       wr_v_o,
  input logic       wr_z_o,
  input logic       wr_c_o
);
  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_bin_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && op_i == 4'd0 && !dec_i) |->
      {flag_c_o, result_o} == ({1'b0, $past(acc_i)} + {1'b0, $past(opd_i)} + {8'b0, $past(carry_i)}));

  p_cmp_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && op_i == 4'd2) |->
      result_o == $past(acc_i) && flag_c_o == ($past(acc_i) >= $past(opd_i)) && !wr_v_o);

  p_logic_cv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && (op_i == 4'd3 || op_i == 4'd4 || op_i == 4'd5 || op_i == 4'd13)) |->
      !wr_c_o && !wr_v_o && wr_z_o && flag_z_o == (result_o == 8'h00));

  p_shl_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && op_i == 4'd6) |-> flag_c_o == $past(acc_i[7]) && !result_o[0]);

  p_incdec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && (op_i == 4'd10 || op_i == 4'd11)) |-> !wr_c_o && !wr_v_o);

  p_unused_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && op_i >= 4'd14) |->
      $countones({wr_n_o, wr_v_o, wr_z_o, wr_c_o}) == 0 && result_o == $past(acc_i));
endmodule

bind acc_alu8 acc_alu8_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_i      (op_i),
  .acc_i     (acc_i),
  .opd_i     (opd_i),
  .carry_i   (carry_i),
  .dec_i     (dec_i),
  .out_valid (out_valid),
  .result_o  (result_o),
  .flag_z_o  (flag_z_o),
  .flag_c_o  (flag_c_o),
  .wr_n_o    (wr_n_o),
  .wr_v_o    (wr_v_o),
  .wr_z_o    (wr_z_o),
  .wr_c_o    (wr_c_o)
);

// File: tb/tb_acc_alu8.sv
module tb_acc_alu8;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, in_valid, carry_i, dec_i;
  logic [3:0] op_i;
  logic [7:0] acc_i, opd_i, result_o;
  logic       out_valid, flag_n_o, flag_v_o, flag_z_o, flag_c_o;
  logic       wr_n_o, wr_v_o, wr_z_o, wr_c_o;

  acc_alu8 dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i),
    .acc_i(acc_i), .opd_i(opd_i), .carry_i(carry_i), .dec_i(dec_i),
    .out_valid(out_valid), .result_o(result_o),
    .flag_n_o(flag_n_o), .flag_v_o(flag_v_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o),
    .wr_n_o(wr_n_o), .wr_v_o(wr_v_o), .wr_z_o(wr_z_o), .wr_c_o(wr_c_o)
  );

  typedef struct packed {
    logic [7:0] res;
    logic [3:0] f;   // {n,v,z,c}
    logic [3:0] w;   // {n,v,z,c} write enables
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    total = 0;
  int    bad   = 0;

  function automatic int sb(int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  // expectation model written from the requirements
  function automatic exp_t model(int op, int a, int m, int c, int d);
    exp_t e;
    int s, lo, hs, sv, t, ta, tb, tc, b;
    int n, v, z, cf;
    e = '0; e.res = a[7:0]; n = 0; v = 0; z = 0; cf = 0;
    case (op)
      0: begin
        e.w = 4'b1111;
        if (d == 0) begin
          s = a + m + c; e.res = s[7:0];
          n = (s >> 7) & 1; z = ((s & 255) == 0); cf = (s > 255);
          v = (((a ^ m) & 128) == 0) && (((a ^ s) & 128) != 0);
        end else begin
          lo = (a & 15) + (m & 15) + c;
          if (lo >= 10) lo = ((lo + 6) & 15) + 16;
          hs = (a & 240) + (m & 240) + lo;
          sv = sb(a & 240) + sb(m & 240) + lo;
          v = (sv < -128) || (sv > 127);
          n = (hs >> 7) & 1;
          z = (((a + m + c) & 255) == 0);
          if (hs >= 160) hs = hs + 96;
          cf = (hs > 255); e.res = hs[7:0];
        end
      end
      1: begin
        e.w = 4'b1111;
        b = 1 - c;
        t = a - m - b;
        z = ((t & 255) == 0); cf = (t >= 0);
        v = (((a ^ m) & (a ^ t) & 128) != 0);
        if (d == 0) begin
          e.res = t[7:0]; n = (t >> 7) & 1;
        end else begin
          ta = (a & 15) - (m & 15) - b;
          if (ta < 0) tb = ((ta - 6) & 15) + ((a & 240) - (m & 240) - 16);
          else        tb = (ta & 15) + ((a & 240) - (m & 240));
          tc = ((tb & 256) != 0) ? tb - 96 : tb;
          e.res = tc[7:0]; n = (tc >> 7) & 1;
        end
      end
      2: begin
        s = a - m; e.res = a[7:0]; e.w = 4'b1011;
        n = (s >> 7) & 1; z = (a == m); cf = (a >= m);
      end
      3, 4, 5, 10, 11, 13: begin
        case (op)
          3: s = a & m;
          4: s = a | m;
          5: s = a ^ m;
          10: s = a + 1;
          11: s = a - 1;
          default: s = m;
        endcase
        e.res = s[7:0]; e.w = 4'b1010;
      end
      6, 7, 8, 9: begin
        case (op)
          6: begin s = a << 1; cf = (a >> 7) & 1; end
          7: begin s = a >> 1; cf = a & 1; end
          8: begin s = (a << 1) | c; cf = (a >> 7) & 1; end
          default: begin s = (c << 7) | (a >> 1); cf = a & 1; end
        endcase
        e.res = s[7:0]; e.w = 4'b1011;
      end
      12: begin
        e.res = a[7:0]; e.w = 4'b1110;
        n = (m >> 7) & 1; v = (m >> 6) & 1; z = ((a & m) == 0);
      end
      default: e.w = 4'b0000;
    endcase
    if ((op >= 3 && op <= 11) || op == 13) begin
      n = e.res[7]; z = (e.res == 8'h00);
    end
    e.f = {n[0], v[0], z[0], cf[0]};
    return e;
  endfunction

  task automatic note(bit ok, string tag, string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  task automatic drive_e(int op, int a, int m, int c, int d, exp_t e, string tag);
    @(negedge clk);
    in_valid = 1'b1; op_i = op[3:0]; acc_i = a[7:0]; opd_i = m[7:0];
    carry_i = c[0]; dec_i = d[0];
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic drive(int op, int a, int m, int c, int d, string tag);
    drive_e(op, a, m, c, d, model(op, a, m, c, d), tag);
  endtask

  task automatic lit(int op, int a, int m, int c, int d, int r, int f, int w, string tag);
    exp_t e;
    e.res = r[7:0]; e.f = f[3:0]; e.w = w[3:0];
    drive_e(op, a, m, c, d, e, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    string tag;
    logic [3:0] fa, wa;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        fa = {flag_n_o, flag_v_o, flag_z_o, flag_c_o};
        wa = {wr_n_o, wr_v_o, wr_z_o, wr_c_o};
        if (exp_q.size() == 0) begin
          note(1'b0, "R1", $sformatf("unexpected output res=%h expected=none", result_o));
        end else begin
          e = exp_q.pop_front();
          tag = tag_q.pop_front();
          total++;
          if (result_o !== e.res || wa !== e.w || (((fa ^ e.f) & e.w) != 4'b0000)) begin
            bad++;
            $display("FAIL %s actual res=%h nvzc=%b wr=%b expected res=%h nvzc=%b wr=%b",
                     tag, result_o, fa & e.w, wa, e.res, e.f & e.w, e.w);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_i = '0; acc_i = '0; opd_i = '0;
    carry_i = 1'b0; dec_i = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    note(out_valid == 1'b0 && result_o == 8'h00 &&
         {wr_n_o, wr_v_o, wr_z_o, wr_c_o} == 4'b0000, "R1",
         $sformatf("reset actual vld=%b res=%h expected vld=0 res=00", out_valid, result_o));
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 binary add
    lit(0, 8'h50, 8'h50, 0, 0, 8'hA0, 4'b1100, 4'b1111, "R2");
    lit(0, 8'hFF, 8'h01, 0, 0, 8'h00, 4'b0011, 4'b1111, "R2");
    // R3 binary subtract
    lit(1, 8'h50, 8'hB0, 1, 0, 8'hA0, 4'b1100, 4'b1111, "R3");
    lit(1, 8'h05, 8'h05, 0, 0, 8'hFF, 4'b1000, 4'b1111, "R3");
    // R4 decimal add
    lit(0, 8'h58, 8'h46, 1, 1, 8'h05, 4'b1101, 4'b1111, "R4");
    lit(0, 8'h99, 8'h01, 0, 1, 8'h00, 4'b1001, 4'b1111, "R4");
    lit(0, 8'h12, 8'h34, 0, 1, 8'h46, 4'b0000, 4'b1111, "R4");
    // R5 decimal subtract
    lit(1, 8'h12, 8'h21, 1, 1, 8'h91, 4'b1000, 4'b1111, "R5");
    lit(1, 8'h40, 8'h01, 1, 1, 8'h39, 4'b0001, 4'b1111, "R5");
    lit(1, 8'h40, 8'h01, 0, 1, 8'h38, 4'b0001, 4'b1111, "R5");
    // R6 compare
    lit(2, 8'h30, 8'h30, 0, 0, 8'h30, 4'b0011, 4'b1011, "R6");
    lit(2, 8'h10, 8'h20, 1, 0, 8'h10, 4'b1000, 4'b1011, "R6");
    // R7 logic and load
    lit(3, 8'hF0, 8'h0F, 1, 0, 8'h00, 4'b0010, 4'b1010, "R7");
    lit(4, 8'h80, 8'h01, 1, 0, 8'h81, 4'b1000, 4'b1010, "R7");
    lit(13, 8'h00, 8'h80, 0, 0, 8'h80, 4'b1000, 4'b1010, "R7");
    // R8 shifts
    lit(6, 8'h81, 8'h00, 0, 0, 8'h02, 4'b0001, 4'b1011, "R8");
    lit(7, 8'h01, 8'h00, 0, 0, 8'h00, 4'b0011, 4'b1011, "R8");
    // R9 rotates
    lit(8, 8'h80, 8'h00, 1, 0, 8'h01, 4'b0001, 4'b1011, "R9");
    lit(9, 8'h01, 8'h00, 1, 0, 8'h80, 4'b1001, 4'b1011, "R9");
    // R10 increment / decrement wrap
    lit(10, 8'hFF, 8'h00, 1, 0, 8'h00, 4'b0010, 4'b1010, "R10");
    lit(11, 8'h00, 8'h00, 0, 0, 8'hFF, 4'b1000, 4'b1010, "R10");
    // R11 bit test
    lit(12, 8'h0F, 8'hC0, 0, 0, 8'h0F, 4'b1110, 4'b1110, "R11");
    // R12 decimal flag ignored outside add/subtract, unused codes
    lit(3, 8'h09, 8'h09, 0, 1, 8'h09, 4'b0000, 4'b1010, "R12");
    lit(14, 8'h5A, 8'h11, 1, 1, 8'h5A, 4'b0000, 4'b0000, "R12");
    lit(15, 8'hA5, 8'h22, 0, 0, 8'hA5, 4'b0000, 4'b0000, "R12");
    idle();
    @(negedge clk);
    note(out_valid == 1'b0, "R1",
         $sformatf("idle actual vld=%b expected vld=0", out_valid));

    // random sweep of every code, both flag modes
    for (int k = 0; k < 3200; k++) begin
      int op, d;
      string tg;
      op = k % 16;
      d  = $urandom % 2;
      case (op)
        0: tg = d ? "R4" : "R2";
        1: tg = d ? "R5" : "R3";
        2: tg = "R6";
        3, 4, 5, 13: tg = "R7";
        6, 7: tg = "R8";
        8, 9: tg = "R9";
        10, 11: tg = "R10";
        12: tg = "R11";
        default: tg = "R12";
      endcase
      drive(op, $urandom % 256, $urandom % 256, $urandom % 2, d, tg);
      if (k % 97 == 0) idle();
    end
    idle();
    repeat (4) @(negedge clk);
    note(exp_q.size() == 0, "R1",
         $sformatf("pending actual=%0d expected=0", exp_q.size()));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule